// File: doc/BRIEF.md
# Interface Subnet-Change Arbiter and Address Rewriter

This block sits in the network interface of one node in a mesh that is split into four parallel subnets. Subnet 0 is always powered. The routers of subnets 1 to 3 can ask to hand a short control flit back to subnet 0, so that the flit does not wake gated routers further along its path. Each of those routers raises a request line. The block registers the requests and picks the highest-order requester. It issues a grant only if one of the virtual channels on its own output toward subnet 0 can be reserved. The grant reaches the router two cycles after that router raised its request.

A router that holds a grant sends its flit over the bypass link, tagged with the number of its subnet. The block rewrites the flit and launches it into subnet 0 on the reserved virtual channel. The rewrite clears the subnet number in the two most significant bits of both the source and destination addresses, and it sets a flag that marks the flit as already moved. The reservation is held until the tail flit has been launched.

Top module: `sc_bypass_ni`

## Requirements
- R1: At most one grant bit is high in any cycle. When several subnets request in the same cycle, the highest-numbered one is granted. `req_i[k]` and `gnt_o[k]` belong to subnet k+1.
- R2: A grant is issued only when at least one subnet-0 virtual channel is marked free on `vc_free_i` and is not already reserved. When there is none, no grant is issued. When there are several, the lowest-numbered one is chosen and reported on `gnt_vc_o` in the same cycle as the grant.
- R3: A request that is high in cycle c produces its grant in cycle c+2. The grant is never seen in cycle c+1, and it lasts one cycle for each request cycle.
- R4: Granting reserves the chosen virtual channel. A reserved channel is not chosen for another grant until it has been released.
- R5: A bypass flit from a subnet that holds an outstanding grant appears on the subnet-0 output one cycle later, on the reserved virtual channel. Its 8-bit source and destination addresses have their two most significant bits (the subnet number) cleared and their lower six bits unchanged. For example, a source of 128 becomes 0 and a destination of 191 becomes 63.
- R6: In the output flit the moved flag is set, and the head bit, tail bit and 16-bit payload are copied from the input. The flit layout, from the MSB down, is: head (bit 34), tail (bit 33), moved flag (bit 32), source [31:24], destination [23:16], payload [15:0].
- R7: When a tail flit is launched, its reservation and its subnet's pending grant are released. A flit without a tail bit keeps both.
- R8: A bypass flit tagged with subnet 0, or tagged with a subnet that has no outstanding grant, is dropped. No output flit appears for it.
- R9: After reset there are no grants, no output flit and no reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Subnet-change requests; bit k is subnet k+1 |
| gnt_o | output | 3 | One-hot grant; bit k is subnet k+1 |
| gnt_vc_o | output | 1 | Subnet-0 virtual channel reserved by the current grant |
| vc_free_i | input | 2 | Free status of each subnet-0 output virtual channel |
| byp_valid_i | input | 1 | Bypass flit valid |
| byp_sub_i | input | 2 | Subnet the bypass flit comes from |
| byp_flit_i | input | 35 | Bypass flit |
| out_valid_o | output | 1 | Rewritten flit valid toward subnet 0 |
| out_vc_o | output | 1 | Virtual channel of the output flit |
| out_flit_o | output | 35 | Rewritten flit |

## Verification
The bench sweeps every request pattern against every free-channel pattern. A design that used the wrong priority, or that granted with no free channel, would produce a wrong grant vector in those sweeps. Grants are sampled in the cycle after the request as well as two cycles after it, which exposes a pipeline that is too short or too long. Reservation stacking is checked by issuing three grants with only two channels. Also checked are a head flit with no tail bit that must keep its channel blocked, and bypass flits from subnet 0 or from subnets with no grant, which must not produce output. A rewrite that cleared the wrong bits, or that left the moved flag clear, is caught by comparing whole flits, including the 128 and 191 address cases.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int ADDR_W   = 8;
    localparam int SUB_BITS = 2;
    localparam int PAY_W    = 16;
    localparam int NSUB     = 1 << SUB_BITS;
    localparam int FLIT_W   = 3 + 2 * ADDR_W + PAY_W;

    typedef struct packed {
        logic              head;
        logic              tail;
        logic              moved;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [PAY_W-1:0]  pay;
    } flit_t;
endpackage

// File: rtl/sc_pick_high.sv
module sc_pick_high #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] sel,
    output logic         any
);
    // Scan upward so the highest set bit is the one that remains.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/sc_vc_pick.sv
module sc_vc_pick #(
    parameter int NVC = 2,
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic [NVC-1:0] avail,
    output logic [VCW-1:0] idx,
    output logic           found
);
    // Scan downward so the lowest available channel is the one that remains.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NVC - 1; i >= 0; i--) begin
            if (avail[i]) begin
                idx   = VCW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_addr_clear.sv
module sc_addr_clear
    import sc_pkg::*;
(
    input  flit_t fin,
    output flit_t fout
);
    localparam int LOW_W = ADDR_W - SUB_BITS;

    always_comb begin
        fout       = fin;
        fout.moved = 1'b1;
        fout.src   = {{SUB_BITS{1'b0}}, fin.src[LOW_W-1:0]};
        fout.dst   = {{SUB_BITS{1'b0}}, fin.dst[LOW_W-1:0]};
    end
endmodule

// File: rtl/sc_bypass_ni.sv
module sc_bypass_ni
    import sc_pkg::*;
#(
    parameter int NVC = 2,
    localparam int NREQ = NSUB - 1,
    localparam int SW   = SUB_BITS,
    localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req_i,
    output logic [NREQ-1:0]   gnt_o,
    output logic [VCW-1:0]    gnt_vc_o,
    input  logic [NVC-1:0]    vc_free_i,
    input  logic              byp_valid_i,
    input  logic [SW-1:0]     byp_sub_i,
    input  logic [FLIT_W-1:0] byp_flit_i,
    output logic              out_valid_o,
    output logic [VCW-1:0]    out_vc_o,
    output logic [FLIT_W-1:0] out_flit_o
);
    typedef struct packed {
        logic [NREQ-1:0]          req;
        logic [NREQ-1:0]          gnt;
        logic [VCW-1:0]           gvc;
        logic [NVC-1:0]           resv;
        logic [NREQ-1:0]          pend;
        logic [NREQ-1:0][VCW-1:0] pvc;
        logic                     ov;
        logic [VCW-1:0]           ovc;
        flit_t                    of;
    } st_t;

    st_t st_d, st_q;

    logic [NREQ-1:0] win;
    logic            win_any;
    logic [VCW-1:0]  pick;
    logic            pick_ok;
    flit_t           rew;
    logic [SW-1:0]   rel;
    logic            accept;

    sc_pick_high #(.N(NREQ)) u_pick (
        .req (st_q.req),
        .sel (win),
        .any (win_any)
    );

    sc_vc_pick #(.NVC(NVC)) u_vc (
        .avail (vc_free_i & ~st_q.resv),
        .idx   (pick),
        .found (pick_ok)
    );

    sc_addr_clear u_rw (
        .fin  (flit_t'(byp_flit_i)),
        .fout (rew)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = req_i;
        rel      = byp_sub_i - SW'(1);
        accept   = byp_valid_i && (byp_sub_i != '0) && st_q.pend[rel];

        // Bypass path: launch the rewritten flit, and free its channel on the tail.
        st_d.ov = accept;
        if (accept) begin
            st_d.of  = rew;
            st_d.ovc = st_q.pvc[rel];
            if (rew.tail) begin
                st_d.resv[st_q.pvc[rel]] = 1'b0;
                st_d.pend[rel]           = 1'b0;
            end
        end

        // Grant path: the winner from the registered requests takes a free channel.
        st_d.gnt = '0;
        if (win_any && pick_ok) begin
            st_d.gnt        = win;
            st_d.gvc        = pick;
            st_d.resv[pick] = 1'b1;
            for (int i = 0; i < NREQ; i++) begin
                if (win[i]) begin
                    st_d.pend[i] = 1'b1;
                    st_d.pvc[i]  = pick;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.gnt;
    assign gnt_vc_o    = st_q.gvc;
    assign out_valid_o = st_q.ov;
    assign out_vc_o    = st_q.ovc;
    assign out_flit_o  = st_q.of;
endmodule

// File: rtl/sc_bypass_ni_chk.sv
module sc_bypass_ni_chk
    import sc_pkg::*;
#(
    parameter int NVC = 2,
    localparam int NREQ = NSUB - 1,
    localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req_i,
    input logic [NREQ-1:0]   gnt_o,
    input logic [VCW-1:0]    gnt_vc_o,
    input logic [NVC-1:0]    vc_free_i,
    input logic              byp_valid_i,
    input logic              out_valid_o,
    input logic [FLIT_W-1:0] out_flit_o
);
    localparam int LOW_W = ADDR_W - SUB_BITS;

    logic [NREQ-1:0] above_g;
    flit_t           of;

    assign above_g = ~(gnt_o | (gnt_o - NREQ'(1)));
    assign of      = flit_t'(out_flit_o);

    p_onehot_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_highest_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> (($past(req_i, 2) & above_g) == '0));

    p_req_two_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> ((gnt_o & $past(req_i, 2)) == gnt_o));

    p_vc_was_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> ((($past(vc_free_i) >> gnt_vc_o) & NVC'(1)) != '0));

    p_sub_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((of.src[ADDR_W-1:LOW_W] == '0) && (of.dst[ADDR_W-1:LOW_W] == '0)));

    p_moved_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> of.moved);

    p_out_follows_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(byp_valid_i));
endmodule

bind sc_bypass_ni sc_bypass_ni_chk #(.NVC(NVC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .gnt_o       (gnt_o),
    .gnt_vc_o    (gnt_vc_o),
    .vc_free_i   (vc_free_i),
    .byp_valid_i (byp_valid_i),
    .out_valid_o (out_valid_o),
    .out_flit_o  (out_flit_o)
);

// File: tb/sc_bypass_ni_test.sv
`timescale 1ns/1ps
module sc_bypass_ni_test;
    import sc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        req_i = '0;
    logic [2:0]        gnt_o;
    logic [0:0]        gnt_vc_o;
    logic [1:0]        vc_free_i = '0;
    logic              byp_valid_i = 1'b0;
    logic [1:0]        byp_sub_i = '0;
    logic [FLIT_W-1:0] byp_flit_i = '0;
    logic              out_valid_o;
    logic [0:0]        out_vc_o;
    logic [FLIT_W-1:0] out_flit_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit [1:0] m_resv = '0;
    int m_pvc [4];

    always #10 clk = ~clk;

    sc_bypass_ni uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_o(gnt_o), .gnt_vc_o(gnt_vc_o),
        .vc_free_i(vc_free_i), .byp_valid_i(byp_valid_i), .byp_sub_i(byp_sub_i),
        .byp_flit_i(byp_flit_i), .out_valid_o(out_valid_o), .out_vc_o(out_vc_o),
        .out_flit_o(out_flit_o)
    );

    function automatic logic [FLIT_W-1:0] mk(bit h, bit t, bit m, logic [7:0] s, logic [7:0] d, logic [15:0] p);
        return {h, t, m, s, d, p};
    endfunction

    task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Request pattern p with free mask v; returns the granted subnet (0 = none).
    task automatic do_req(input logic [2:0] p, input logic [1:0] v, output int wsub);
        logic [2:0] eg;
        logic [1:0] av;
        int evc;
        eg = '0;
        for (int b = 0; b < 3; b++) if (p[b]) eg = 3'(1 << b);
        av  = v & ~m_resv;
        evc = -1;
        for (int i = 1; i >= 0; i--) if (av[i]) evc = i;
        if (evc < 0) eg = '0;
        req_i = p; vc_free_i = v;
        @(negedge clk);
        req_i = '0;
        chk(gnt_o == '0, "R3 early", 64'(gnt_o), 0);
        @(negedge clk);
        chk(gnt_o == eg, "R1 R2 grant", 64'(gnt_o), 64'(eg));
        wsub = 0;
        if (eg != '0) begin
            chk(int'(gnt_vc_o) == evc, "R2 R4 vc", 64'(gnt_vc_o), 64'(evc));
            for (int b = 0; b < 3; b++) if (eg[b]) wsub = b + 1;
            m_resv[evc] = 1'b1;
            m_pvc[wsub] = evc;
        end
        @(negedge clk);
        chk(gnt_o == '0, "R3 single pulse", 64'(gnt_o), 0);
    endtask

    task automatic send(int s, bit h, bit t, logic [7:0] sa, logic [7:0] da, logic [15:0] p, bit exp_out);
        logic [FLIT_W-1:0] ef;
        byp_valid_i = 1'b1; byp_sub_i = 2'(s); byp_flit_i = mk(h, t, 1'b0, sa, da, p);
        @(negedge clk);
        byp_valid_i = 1'b0;
        chk(out_valid_o == exp_out, exp_out ? "R5 valid" : "R8 drop", 64'(out_valid_o), 64'(exp_out));
        if (exp_out) begin
            ef = mk(h, t, 1'b1, sa & 8'h3F, da & 8'h3F, p);
            chk(out_flit_o == ef, "R5 R6 flit", 64'(out_flit_o), 64'(ef));
            chk(int'(out_vc_o) == m_pvc[s], "R5 vc", 64'(out_vc_o), 64'(m_pvc[s]));
            if (t) m_resv[m_pvc[s]] = 1'b0;
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        chk(gnt_o == '0, "R9 grant", 64'(gnt_o), 0);
        chk(out_valid_o == 1'b0, "R9 out", 64'(out_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: no reservations after reset, so channel 0 is the one chosen
        do_req(3'b001, 2'b01, w);
        send(1, 1, 1, 8'd128, 8'd191, 16'hA5A5, 1);

        // R1 R2 R3: sweep every request pattern against every free mask
        for (int p = 0; p < 8; p++) begin
            for (int v = 0; v < 4; v++) begin
                do_req(3'(p), 2'(v), w);
                if (w != 0)
                    send(w, 1, 1, {2'(w), 6'(p * 4 + v)}, {2'(3 - w), 6'(63 - p * 4 - v)}, 16'(p * 257 + v), 1);
            end
        end

        // R4: reservations stack; a third request finds none
        do_req(3'b100, 2'b11, w);
        do_req(3'b010, 2'b11, w);
        do_req(3'b001, 2'b11, w);
        send(3, 1, 1, 8'hC1, 8'h82, 16'h1234, 1);
        do_req(3'b001, 2'b11, w);
        send(2, 1, 1, 8'h85, 8'hFF, 16'h0F0F, 1);
        send(1, 1, 1, 8'h7F, 8'h40, 16'hBEEF, 1);

        // R7: a head flit without a tail keeps its channel
        do_req(3'b001, 2'b01, w);
        send(1, 1, 0, 8'h45, 8'hC6, 16'h0001, 1);
        do_req(3'b010, 2'b01, w);
        send(1, 0, 1, 8'h45, 8'hC6, 16'h0002, 1);
        do_req(3'b010, 2'b01, w);
        send(2, 1, 1, 8'h99, 8'h11, 16'h0003, 1);

        // R8: no grant pending, and subnet 0
        send(2, 1, 1, 8'h80, 8'h80, 16'h0004, 0);
        send(0, 1, 1, 8'h00, 8'h01, 16'h0005, 0);
        send(1, 1, 1, 8'h40, 8'h40, 16'h0006, 0);
        // R8: after a drop the channel state is unchanged, so channel 1 is granted
        do_req(3'b100, 2'b10, w);
        send(3, 1, 1, 8'hFF, 8'hC0, 16'h0007, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule